// File: doc/BRIEF.md
# Cascadable Segment Line Capture

This block collects one display line of pixel bits for a group of segment columns. The bits arrive as nibbles on a narrow parallel bus, one nibble per rising edge of a shift clock. It places them in a line register that the line-memory logic reads. Several copies share the same bus and shift clock and form a chain. Each copy accepts nibbles only while its active-low enable input is low. Once it holds its full line, it pulls its own enable output low, which enables the next copy. The host controller takes no part in this hand-over.

While the enable input is high, the block forces the shift clock and the bus it uses inside to zero, so that nothing inside toggles. A direction input mirrors the way the line fills. The falling edge of a line pulse ends the line, clears the nibble count and raises the enable output again. The captured bits are kept for the line memory to take.

All inputs are sampled on a system clock `clk`. The block finds edges of `shift_clk` and `line_pulse` by comparing each sample with the one before. It is controlled by a three-state machine:
- `ST_WAIT`: no nibble taken yet on this line.
- `ST_FILL`: part of the line taken.
- `ST_FULL`: the whole line held and the enable output low.

The transitions are:
- `take_first` (WAIT→FILL) on the first accepted nibble. When the line is a single beat, the first nibble goes straight from WAIT to FULL.
- `take_last` (FILL→FULL) on the last nibble.
- `line_end` (any state→WAIT) on the falling edge of the line pulse. `line_end` overrides any nibble seen in the same cycle.

Top module: `seg_line_capture`

## Requirements
- R1: After reset, `en_out_n` is 1 and `line_data` is all zeros.
- R2: Each rising edge of `shift_clk` seen while `en_in_n` is 0 and the line is not full captures the 4-bit value on `data_in` as one beat. A line is 80 bits, which is 20 beats.
- R3: With `dir_rev` = 0, beat k (counted from 0) writes `data_in[i]` into `line_data[4k+i]`. The first beat therefore fills bits 3..0.
- R4: With `dir_rev` = 1, beat k writes `data_in[i]` into `line_data[79-4k-i]`. The first beat fills bits 79..76 with its bit order mirrored.
- R5: `en_out_n` stays 1 until the 20th beat has been captured. It goes to 0 in the cycle after that beat is taken.
- R6: Shift-clock edges after the 20th beat and before the next line-pulse fall are ignored. `line_data` holds and `en_out_n` stays 0.
- R7: While `en_in_n` is 1, shift-clock edges and bus values have no effect. No beat is counted and `line_data` holds.
- R8: A falling edge of `line_pulse` returns `en_out_n` to 1 in the next cycle and clears the beat count. It leaves `line_data` unchanged, and the next beat goes into the first slot again.
- R9: Two blocks chained (the first block's `en_out_n` driving the second block's `en_in_n`, with a shared bus) split a run of 40 beats. The first block takes beats 0..19 and the second takes beats 20..39.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in_n | input | 1 | Active-low enable from the previous block (tied low on the first) |
| shift_clk | input | 1 | Shift clock; a rising edge presents one beat |
| data_in | input | 4 | Beat data bus |
| dir_rev | input | 1 | Fill direction: 0 forward from bit 0, 1 mirrored from the top bit |
| line_pulse | input | 1 | Line pulse; its falling edge ends the line |
| en_out_n | output | 1 | Active-low enable to the next block; 0 when the line is full |
| line_data | output | 80 | Captured line register |

## Verification
The bench builds two copies with the default widths: 80-bit lines from a 4-bit bus, which is 20 beats a line. It chains them so that the hand-over from the first copy to the second happens on the 21st shift edge of a shared run. With these values the boundary at exactly the 20th beat can be reached, as can the mirrored fill that meets the top slot first. Extra edges after a full line also fall on a live neighbour, so a block that failed to ignore them would corrupt an observable register. Random beat data and random direction per line fill every slot of both copies with varied nibbles.

// File: rtl/seg_cap_pkg.sv
package seg_cap_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_FILL = 2'd1,
        ST_FULL = 2'd2
    } cap_state_e;

endpackage

// File: rtl/seg_cap_gate.sv
// Power-save gate: while the block is disabled the shift clock and data
// bus seen by the capture logic are held at zero.
module seg_cap_gate #(
    parameter int BUS_W = 4
) (
    input  logic             en_in_n,
    input  logic             shift_clk,
    input  logic [BUS_W-1:0] data_in,
    output logic             sclk_g,
    output logic [BUS_W-1:0] bus_g
);

    always_comb begin
        if (en_in_n) begin
            sclk_g = 1'b0;
            bus_g  = '0;
        end else begin
            sclk_g = shift_clk;
            bus_g  = data_in;
        end
    end

endmodule

// File: rtl/seg_cap_edge.sv
// Samples a level each clock and reports rising and falling transitions.
module seg_cap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level;
        end
    end

    always_comb begin
        rise = level & ~level_q;
        fall = ~level & level_q;
    end

endmodule

// File: rtl/seg_cap_beat_cnt.sv
// Beat index within the line; saturates at the last beat.
module seg_cap_beat_cnt #(
    parameter int BEATS = 20,
    localparam int CW   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] idx,
    output logic          last
);

    localparam logic [CW-1:0] LAST_IDX = CW'(BEATS - 1);

    logic [CW-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= '0;
        end else if (inc && (idx_q != LAST_IDX)) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        idx  = idx_q;
        last = (idx_q == LAST_IDX);
    end

endmodule

// File: rtl/seg_cap_reg.sv
// Line register split into beat-wide slots; each slot decodes its own
// write strobe for the forward and mirrored fill orders.
module seg_cap_reg #(
    parameter int LINE_BITS = 80,
    parameter int BUS_W     = 4,
    localparam int BEATS    = LINE_BITS / BUS_W,
    localparam int CW       = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic                 rev,
    input  logic [CW-1:0]        idx,
    input  logic [BUS_W-1:0]     nib,
    output logic [LINE_BITS-1:0] line
);

    logic [BUS_W-1:0] nib_mir;

    for (genvar b = 0; b < BUS_W; b++) begin : g_mir
        assign nib_mir[b] = nib[BUS_W-1-b];
    end

    for (genvar s = 0; s < BEATS; s++) begin : g_slot
        logic [BUS_W-1:0] slot_q;
        logic             hit_fwd;
        logic             hit_rev;

        assign hit_fwd = wr && !rev && (idx == CW'(s));
        assign hit_rev = wr &&  rev && (idx == CW'(BEATS - 1 - s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (hit_fwd) begin
                slot_q <= nib;
            end else if (hit_rev) begin
                slot_q <= nib_mir;
            end
        end

        assign line[s*BUS_W +: BUS_W] = slot_q;
    end

endmodule

// File: rtl/seg_line_capture.sv
module seg_line_capture
    import seg_cap_pkg::*;
#(
    parameter int LINE_BITS = 80,
    parameter int BUS_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_in_n,
    input  logic                 shift_clk,
    input  logic [BUS_W-1:0]     data_in,
    input  logic                 dir_rev,
    input  logic                 line_pulse,
    output logic                 en_out_n,
    output logic [LINE_BITS-1:0] line_data
);

    localparam int BEATS = LINE_BITS / BUS_W;
    localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

    cap_state_e       state_q;
    cap_state_e       state_nx;
    logic             sclk_g;
    logic [BUS_W-1:0] bus_g;
    logic             beat_rise;
    logic             beat_fall_unused;
    logic             lp_rise_unused;
    logic             lp_fall;
    logic             accept;
    logic [CW-1:0]    beat_idx;
    logic             beat_last;

    seg_cap_gate #(.BUS_W(BUS_W)) gate_i (
        .en_in_n   (en_in_n),
        .shift_clk (shift_clk),
        .data_in   (data_in),
        .sclk_g    (sclk_g),
        .bus_g     (bus_g)
    );

    seg_cap_edge sclk_edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sclk_g),
        .rise  (beat_rise),
        .fall  (beat_fall_unused)
    );

    seg_cap_edge lp_edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .level (line_pulse),
        .rise  (lp_rise_unused),
        .fall  (lp_fall)
    );

    seg_cap_beat_cnt #(.BEATS(BEATS)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (lp_fall),
        .inc   (accept),
        .idx   (beat_idx),
        .last  (beat_last)
    );

    seg_cap_reg #(.LINE_BITS(LINE_BITS), .BUS_W(BUS_W)) reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (accept),
        .rev   (dir_rev),
        .idx   (beat_idx),
        .nib   (bus_g),
        .line  (line_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_nx;
        end
    end

    // Next state: line_end overrides everything
    always_comb begin
        state_nx = state_q;
        if (lp_fall) begin
            state_nx = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_WAIT: if (accept) state_nx = beat_last ? ST_FULL : ST_FILL;
                ST_FILL: if (accept && beat_last) state_nx = ST_FULL;
                ST_FULL: state_nx = ST_FULL;
                default: state_nx = ST_WAIT;
            endcase
        end
    end

    // Outputs and strobes
    always_comb begin
        accept   = beat_rise && !lp_fall && (state_q != ST_FULL);
        en_out_n = (state_q != ST_FULL);
    end

endmodule

// File: rtl/seg_line_capture_chk.sv
module seg_line_capture_chk #(
    parameter int LINE_BITS = 80,
    parameter int BUS_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en_in_n,
    input logic                 shift_clk,
    input logic                 line_pulse,
    input logic                 en_out_n,
    input logic [LINE_BITS-1:0] line_data
);

    localparam int BEATS = LINE_BITS / BUS_W;
    localparam int NW    = $clog2(BEATS + 1) + 1;

    logic          seen_q;
    logic          lp_q;
    logic [NW-1:0] beats_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            lp_q    <= 1'b0;
            beats_q <= '0;
        end else begin
            seen_q <= shift_clk && !en_in_n;
            lp_q   <= line_pulse;
            if (lp_q && !line_pulse) begin
                beats_q <= '0;
            end else if (shift_clk && !en_in_n && !seen_q && en_out_n) begin
                beats_q <= beats_q + 1'b1;
            end
        end
    end

    // R5
    full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_out_n) |-> (beats_q == NW'(BEATS)));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_out_n |=> $stable(line_data));

    // R7
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_in_n |=> $stable(line_data));

    // R8
    line_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_pulse) |=> en_out_n);

endmodule

bind seg_line_capture seg_line_capture_chk #(
    .LINE_BITS (LINE_BITS),
    .BUS_W     (BUS_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_in_n    (en_in_n),
    .shift_clk  (shift_clk),
    .line_pulse (line_pulse),
    .en_out_n   (en_out_n),
    .line_data  (line_data)
);

// File: tb/seg_line_capture_tb_top.sv
module seg_line_capture_tb_top;

    localparam int LB = 80;
    localparam int BW = 4;
    localparam int NB = LB / BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_first_n = 1'b1;
    logic          shift_clk = 1'b0;
    logic [BW-1:0] data_in = '0;
    logic          dir_rev = 1'b0;
    logic          line_pulse = 1'b0;
    logic          en_mid_n;
    logic          en_last_n;
    logic [LB-1:0] line_a;
    logic [LB-1:0] line_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [BW-1:0] nibs [0:2*NB-1];

    always #10 clk = ~clk;

    seg_line_capture #(.LINE_BITS(LB), .BUS_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_in_n(en_first_n), .shift_clk(shift_clk),
        .data_in(data_in), .dir_rev(dir_rev), .line_pulse(line_pulse),
        .en_out_n(en_mid_n), .line_data(line_a)
    );

    seg_line_capture #(.LINE_BITS(LB), .BUS_W(BW)) dut2_i (
        .clk(clk), .rst_n(rst_n), .en_in_n(en_mid_n), .shift_clk(shift_clk),
        .data_in(data_in), .dir_rev(dir_rev), .line_pulse(line_pulse),
        .en_out_n(en_last_n), .line_data(line_b)
    );

    function automatic logic [LB-1:0] exp_line(int base, int cnt, bit rev, logic [LB-1:0] old);
        logic [LB-1:0] r = old;
        for (int k = 0; k < cnt; k++)
            for (int i = 0; i < BW; i++)
                if (!rev) r[BW*k+i] = nibs[base+k][i];
                else      r[LB-1-BW*k-i] = nibs[base+k][i];
        return r;
    endfunction

    task automatic check(string tag, logic [LB-1:0] act, logic [LB-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic beat(logic [BW-1:0] v, bit rev);
        @(negedge clk);
        shift_clk = 1'b1; data_in = v; dir_rev = rev;
        @(negedge clk);
        shift_clk = 1'b0;
    endtask

    task automatic end_line;
        @(negedge clk); line_pulse = 1'b1;
        @(negedge clk); line_pulse = 1'b0;
        @(negedge clk);
    endtask

    task automatic fill_nibs;
        for (int k = 0; k < 2*NB; k++) nibs[k] = BW'($urandom);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [LB-1:0] held;
        logic [LB-1:0] held_b;
        bit rv;
        void'($urandom(32'h5EED_0C0A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 en_out_n", LB'(en_mid_n), LB'(1));
        check("R1 line_data", line_a, '0);

        // R7 disabled: edges and bus ignored
        for (int k = 0; k < 6; k++) beat(4'hF, 1'b0);
        check("R7 line_data held", line_a, '0);
        check("R7 en_out_n", LB'(en_mid_n), LB'(1));
        en_first_n = 1'b0;

        // R2/R3/R5 forward line
        fill_nibs();
        for (int k = 0; k < NB-1; k++) beat(nibs[k], 1'b0);
        check("R5 en_out_n before last beat", LB'(en_mid_n), LB'(1));
        beat(nibs[NB-1], 1'b0);
        check("R5 en_out_n after 20th beat", LB'(en_mid_n), LB'(0));
        check("R3 forward fill", line_a, exp_line(0, NB, 1'b0, '0));
        held = line_a;

        // R6 extra edges ignored (taken by the chained block)
        for (int k = 0; k < 3; k++) beat(BW'($urandom), 1'b0);
        check("R6 line held", line_a, held);
        check("R6 en_out_n stays low", LB'(en_mid_n), LB'(0));

        // R8 line end
        end_line();
        check("R8 en_out_n returns high", LB'(en_mid_n), LB'(1));
        check("R8 line held", line_a, held);
        fill_nibs();
        for (int k = 0; k < 3; k++) beat(nibs[k], 1'b0);
        check("R8 restart at first slot", line_a, exp_line(0, 3, 1'b0, held));
        end_line();

        // R4 reverse line
        fill_nibs();
        held = line_a;
        for (int k = 0; k < 5; k++) beat(nibs[k], 1'b1);
        check("R4 partial mirrored fill", line_a, exp_line(0, 5, 1'b1, held));
        for (int k = 5; k < NB; k++) beat(nibs[k], 1'b1);
        check("R4 mirrored fill", line_a, exp_line(0, NB, 1'b1, '0));
        check("R5 en_out_n reverse", LB'(en_mid_n), LB'(0));
        end_line();

        // R9 cascade, random direction per line
        for (int ln = 0; ln < 6; ln++) begin
            fill_nibs();
            rv = ln[0] ^ 1'($urandom);
            held_b = line_b;
            for (int k = 0; k < 2*NB; k++) begin
                beat(nibs[k], rv);
                if (k == NB-1) check("R9 second block idle", line_b, held_b);
            end
            check("R9 first block", line_a, exp_line(0, NB, rv, '0));
            check("R9 second block", line_b, exp_line(NB, NB, rv, '0));
            check("R9 chain end enable", LB'(en_last_n), LB'(0));
            end_line();
            check("R8 chain re-armed", LB'({en_mid_n, en_last_n}), LB'(2'b11));
        end

        // R7 disabled mid-line after a line end
        en_first_n = 1'b1;
        held = line_a;
        for (int k = 0; k < 4; k++) beat(BW'($urandom), 1'b0);
        check("R7 disabled after line end", line_a, held);
        check("R7 en_out_n disabled", LB'(en_mid_n), LB'(1));

        done = 1;
        summary();
    end

endmodule